// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block supplies the answers to the three identification commands of a serial NOR flash slave. A serial front end, which is not part of the block, turns the bus traffic into bytes. Each byte the host shifts in arrives as a write strobe, and each byte the host wants to clock out arrives as a read request. The block returns one response byte per read request, one cycle later, and the front end shifts it out on MISO. All identification values are parameters. Only the 0x90 command, and the legacy command in its alternate variant, look at the written address.

A frame lasts as long as `frm_active` is high. The first byte written in a frame is the opcode. The next three bytes are address bytes, and any further written bytes count as surplus. The write phase ends at the first accepted read request. When `frm_active` drops, all frame state is cleared. Opcode 0xAB is the legacy signature command, 0x90 is the manufacturer/device command and 0x9F is the JEDEC ID command. All three are parameters. On the bus, bytes travel MSB first in SPI mode 0.

Top module: `id_responder`

## Requirements
- R1: For opcode 0x90, a frame with fewer than four written bytes (opcode plus three address bytes) answers every read with 0xFF.
- R2: For opcode 0x90 with a complete header, read number i (counted from 0) returns MFR_ID when (address + surplus + i) is even and DEV_ID when it is odd, for any number of reads. Only bit 0 of the last address byte affects this parity.
- R3: Each written byte after the fourth adds one to the response offset of R2, with no limit on how many such bytes there are.
- R4: With SIG_AS_PAIR = 0, opcode 0xAB with at least four written bytes answers every read with SIG_ID, whatever the address. With fewer written bytes it answers 0xFF.
- R5: With SIG_AS_PAIR = 1, opcode 0xAB behaves exactly as opcode 0x90 in R1 to R3.
- R6: Opcode 0x9F answers reads 0, 1 and 2 with MFR_ID, TYPE_ID and CAP_ID in that order, and 0xFF for read 3 onward. Written bytes after the opcode do not change this.
- R7: A frame whose opcode is none of the three, or in which nothing was written, answers every read with 0xFF.
- R8: A read request taken while `frm_active` is high gives `rd_valid` high with its byte in the next cycle. No other cycle has `rd_valid` high, and a read request while `frm_active` is low gives nothing.
- R9: A written byte that arrives after the first read of a frame, or in the same cycle as a read request, is ignored. Later response bytes are exactly as if it had never been sent.
- R10: Dropping `frm_active` discards the opcode, the header count, the offset and the read count. The next frame starts fresh.
- R11: During and right after reset, `rd_valid` is low and `rd_byte` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_active | input | 1 | High while the chip select of the frame is asserted |
| wr_valid | input | 1 | A byte written by the host is present on wr_byte |
| wr_byte | input | 8 | Written byte |
| rd_req | input | 1 | The host wants the next response byte |
| rd_valid | output | 1 | rd_byte carries the response to the request of the previous cycle |
| rd_byte | output | 8 | Response byte |

## Verification
The bench builds two copies of the block, both with manufacturer 0xC2, memory type 0x20, capacity 0x17 and device and signature bytes of 0x16. One copy uses the basic legacy signature (SIG_AS_PAIR = 0) and the other the alternate one (SIG_AS_PAIR = 1). Every frame goes to both copies, so the same 0xAB traffic must give a constant byte from one copy and an alternating pair from the other. Because the two ID bytes differ, any slip in parity from the address bit, from surplus bytes, or from the read count shows up as a wrong byte. Frames with seven surplus bytes run past the saturating header counter and show that the parity keeps advancing beyond it.

// File: rtl/id_resp_pkg.sv
package id_resp_pkg;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_SIG   = 2'd1,
      CMD_PAIR  = 2'd2,
      CMD_JEDEC = 2'd3
   } id_cmd_e;

   typedef struct packed {
      id_cmd_e cmd;
      logic    hdr_ok;
      logic    phase;
   } frame_info_t;

   localparam logic [7:0] FILL_BYTE = 8'hFF;
   localparam int         JEDEC_LEN = 3;

endpackage

// File: rtl/id_frame_capture.sv
module id_frame_capture
   import id_resp_pkg::*;
#(
   parameter logic [7:0] OP_SIG      = 8'hAB,
   parameter logic [7:0] OP_PAIR     = 8'h90,
   parameter logic [7:0] OP_JEDEC    = 8'h9F,
   parameter bit         SIG_AS_PAIR = 1'b0,
   parameter int         ADDR_BYTES  = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frm_active,
   input  logic        wr_valid,
   input  logic [7:0]  wr_byte,
   input  logic        rd_req,
   output frame_info_t info
);

   localparam int              HDR_LEN  = ADDR_BYTES + 1;
   localparam int              CNT_W    = $clog2(HDR_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(HDR_LEN);
   localparam logic [CNT_W-1:0] LSB_IDX  = CNT_W'(HDR_LEN - 1);

   logic [CNT_W-1:0] cnt_q;
   id_cmd_e          cmd_q;
   id_cmd_e          cmd_dec;
   id_cmd_e          sig_cmd;
   logic             phase_q;
   logic             reading_q;
   logic             take;

   // variant choice for the legacy signature opcode
   generate
      if (SIG_AS_PAIR) begin : g_sig_pair
         assign sig_cmd = CMD_PAIR;
      end else begin : g_sig_basic
         assign sig_cmd = CMD_SIG;
      end
   endgenerate

   always_comb begin
      if (wr_byte == OP_PAIR)       cmd_dec = CMD_PAIR;
      else if (wr_byte == OP_SIG)   cmd_dec = sig_cmd;
      else if (wr_byte == OP_JEDEC) cmd_dec = CMD_JEDEC;
      else                          cmd_dec = CMD_NONE;
   end

   // writes count only before the first read of the frame
   assign take = frm_active && wr_valid && !rd_req && !reading_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cmd_q     <= CMD_NONE;
         phase_q   <= 1'b0;
         reading_q <= 1'b0;
      end else if (!frm_active) begin
         cnt_q     <= '0;
         cmd_q     <= CMD_NONE;
         phase_q   <= 1'b0;
         reading_q <= 1'b0;
      end else begin
         if (rd_req) reading_q <= 1'b1;
         if (take) begin
            if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0) cmd_q <= cmd_dec;
            if (cnt_q == LSB_IDX)       phase_q <= wr_byte[0];
            else if (cnt_q == CNT_FULL) phase_q <= ~phase_q;
         end
      end
   end

   assign info = '{cmd: cmd_q, hdr_ok: (cnt_q == CNT_FULL), phase: phase_q};

endmodule

// File: rtl/id_read_seq.sv
module id_read_seq #(
   parameter int MAX_IDX = 3,
   localparam int IDX_W  = $clog2(MAX_IDX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm_active,
   input  logic             rd_go,
   output logic [IDX_W-1:0] ridx,
   output logic             rpar
);

   localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(MAX_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ridx <= '0;
         rpar <= 1'b0;
      end else if (!frm_active) begin
         ridx <= '0;
         rpar <= 1'b0;
      end else if (rd_go) begin
         if (ridx != IDX_TOP) ridx <= ridx + 1'b1;
         rpar <= ~rpar;
      end
   end

endmodule

// File: rtl/id_byte_mux.sv
module id_byte_mux
   import id_resp_pkg::*;
#(
   parameter logic [7:0] MFR_ID  = 8'hC2,
   parameter logic [7:0] DEV_ID  = 8'h16,
   parameter logic [7:0] SIG_ID  = 8'h16,
   parameter logic [7:0] TYPE_ID = 8'h20,
   parameter logic [7:0] CAP_ID  = 8'h17,
   parameter int         IDX_W   = 2
) (
   input  frame_info_t      info,
   input  logic [IDX_W-1:0] ridx,
   input  logic             rpar,
   output logic [7:0]       byte_out
);

   localparam logic [7:0] JID [JEDEC_LEN] = '{MFR_ID, TYPE_ID, CAP_ID};

   logic [7:0] jedec_byte;
   logic [7:0] pair_byte;

   always_comb begin
      jedec_byte = FILL_BYTE;
      for (int k = 0; k < JEDEC_LEN; k++) begin
         if (ridx == IDX_W'(k)) jedec_byte = JID[k];
      end
   end

   assign pair_byte = (info.phase ^ rpar) ? DEV_ID : MFR_ID;

   always_comb begin
      case (info.cmd)
         CMD_JEDEC: byte_out = jedec_byte;
         CMD_PAIR:  byte_out = info.hdr_ok ? pair_byte : FILL_BYTE;
         CMD_SIG:   byte_out = info.hdr_ok ? SIG_ID : FILL_BYTE;
         default:   byte_out = FILL_BYTE;
      endcase
   end

endmodule

// File: rtl/id_responder.sv
module id_responder
   import id_resp_pkg::*;
#(
   parameter logic [7:0] MFR_ID      = 8'hC2,
   parameter logic [7:0] DEV_ID      = 8'h16,
   parameter logic [7:0] SIG_ID      = 8'h16,
   parameter logic [7:0] TYPE_ID     = 8'h20,
   parameter logic [7:0] CAP_ID      = 8'h17,
   parameter logic [7:0] OP_SIG      = 8'hAB,
   parameter logic [7:0] OP_PAIR     = 8'h90,
   parameter logic [7:0] OP_JEDEC    = 8'h9F,
   parameter bit         SIG_AS_PAIR = 1'b0,
   parameter int         ADDR_BYTES  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frm_active,
   input  logic       wr_valid,
   input  logic [7:0] wr_byte,
   input  logic       rd_req,
   output logic       rd_valid,
   output logic [7:0] rd_byte
);

   localparam int IDX_W = $clog2(JEDEC_LEN + 1);

   generate
      if (ADDR_BYTES < 1 || ADDR_BYTES > 6) begin : g_bad_addr
         $error("id_responder: ADDR_BYTES must lie in 1..6");
      end
      if (OP_SIG == OP_PAIR || OP_SIG == OP_JEDEC || OP_PAIR == OP_JEDEC) begin : g_bad_ops
         $error("id_responder: the three opcodes must differ");
      end
   endgenerate

   frame_info_t      info;
   logic [IDX_W-1:0] ridx;
   logic             rpar;
   logic             rd_go;
   logic [7:0]       resp;

   assign rd_go = frm_active && rd_req;

   id_frame_capture #(
      .OP_SIG     (OP_SIG),
      .OP_PAIR    (OP_PAIR),
      .OP_JEDEC   (OP_JEDEC),
      .SIG_AS_PAIR(SIG_AS_PAIR),
      .ADDR_BYTES (ADDR_BYTES)
   ) u_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_active(frm_active),
      .wr_valid  (wr_valid),
      .wr_byte   (wr_byte),
      .rd_req    (rd_req),
      .info      (info)
   );

   id_read_seq #(
      .MAX_IDX(JEDEC_LEN)
   ) u_rseq (
      .clk       (clk),
      .rst_n     (rst_n),
      .frm_active(frm_active),
      .rd_go     (rd_go),
      .ridx      (ridx),
      .rpar      (rpar)
   );

   id_byte_mux #(
      .MFR_ID (MFR_ID),
      .DEV_ID (DEV_ID),
      .SIG_ID (SIG_ID),
      .TYPE_ID(TYPE_ID),
      .CAP_ID (CAP_ID),
      .IDX_W  (IDX_W)
   ) u_mux (
      .info    (info),
      .ridx    (ridx),
      .rpar    (rpar),
      .byte_out(resp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_byte  <= FILL_BYTE;
      end else begin
         rd_valid <= rd_go;
         if (rd_go) rd_byte <= resp;
      end
   end

endmodule

// File: rtl/id_responder_chk.sv
module id_responder_chk #(
   parameter logic [7:0] MFR_ID     = 8'hC2,
   parameter logic [7:0] DEV_ID     = 8'h16,
   parameter logic [7:0] OP_SIG     = 8'hAB,
   parameter logic [7:0] OP_PAIR    = 8'h90,
   parameter logic [7:0] OP_JEDEC   = 8'h9F,
   parameter int         ADDR_BYTES = 3
) (
   input logic       clk,
   input logic       rst_n,
   input logic       frm_active,
   input logic       wr_valid,
   input logic [7:0] wr_byte,
   input logic       rd_req,
   input logic       rd_valid,
   input logic [7:0] rd_byte
);

   localparam int HDR = ADDR_BYTES + 1;

   logic [7:0] op_q;
   int         wn_q;
   int         rn_q;
   logic       rd_seen_q;
   logic       have_prev_q;
   logic [7:0] last_q;
   logic       in_frame;

   // observed frame state, built only from the ports
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= 8'h00; wn_q <= 0; rn_q <= 0;
         rd_seen_q <= 1'b0; have_prev_q <= 1'b0; last_q <= 8'h00;
      end else if (!frm_active) begin
         op_q <= 8'h00; wn_q <= 0; rn_q <= 0;
         rd_seen_q <= 1'b0; have_prev_q <= 1'b0; last_q <= 8'h00;
      end else begin
         if (wr_valid && !rd_req && !rd_seen_q) begin
            if (wn_q == 0) op_q <= wr_byte;
            if (wn_q < HDR) wn_q <= wn_q + 1;
         end
         if (rd_req) begin
            rd_seen_q <= 1'b1;
            if (rn_q < 4) rn_q <= rn_q + 1;
         end
         if (rd_valid) begin
            have_prev_q <= 1'b1;
            last_q      <= rd_byte;
         end
      end
   end

   assign in_frame = rd_valid && frm_active;

   // R8: a taken request yields a valid byte in the next cycle
   a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_active && rd_req) |=> rd_valid);

   // R8: no valid byte without a taken request
   a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(frm_active && rd_req) |=> !rd_valid);

   // R7: unknown opcode or empty frame reads as 0xFF
   a_r7_unknown_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && $past(frm_active) &&
       (wn_q == 0 || (op_q != OP_SIG && op_q != OP_PAIR && op_q != OP_JEDEC)))
      |-> rd_byte == 8'hFF);

   // R6: JEDEC answer beyond the third byte is 0xFF
   a_r6_jedec_tail_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && $past(frm_active) && wn_q > 0 && op_q == OP_JEDEC && rn_q >= 4)
      |-> rd_byte == 8'hFF);

   // R1: short header gives 0xFF for the address-taking commands
   a_r1_short_hdr_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && $past(frm_active) && wn_q > 0 && wn_q < HDR &&
       (op_q == OP_PAIR || op_q == OP_SIG))
      |-> rd_byte == 8'hFF);

   // R2: consecutive answers of 0x90 alternate
   a_r2_pair_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && $past(frm_active) && op_q == OP_PAIR && wn_q == HDR &&
       have_prev_q && (MFR_ID != DEV_ID))
      |-> rd_byte != last_q);

endmodule

bind id_responder id_responder_chk #(
   .MFR_ID    (MFR_ID),
   .DEV_ID    (DEV_ID),
   .OP_SIG    (OP_SIG),
   .OP_PAIR   (OP_PAIR),
   .OP_JEDEC  (OP_JEDEC),
   .ADDR_BYTES(ADDR_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frm_active(frm_active),
   .wr_valid  (wr_valid),
   .wr_byte   (wr_byte),
   .rd_req    (rd_req),
   .rd_valid  (rd_valid),
   .rd_byte   (rd_byte)
);

// File: tb/test_id_responder.sv
module test_id_responder;

   localparam logic [7:0] MFR  = 8'hC2;
   localparam logic [7:0] DEV  = 8'h16;
   localparam logic [7:0] SIG  = 8'h16;
   localparam logic [7:0] TYP  = 8'h20;
   localparam logic [7:0] CAP  = 8'h17;
   localparam logic [7:0] OPS  = 8'hAB;
   localparam logic [7:0] OPP  = 8'h90;
   localparam logic [7:0] OPJ  = 8'h9F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm_active = 1'b0;
   logic       wr_valid = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       rd_req = 1'b0;
   logic       v0, v1;
   logic [7:0] b0, b1;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] wq[$];
   logic [7:0] stim[$];
   int         rcount = 0;
   bit         reading = 0;

   always #4 clk = ~clk;

   id_responder #(
      .MFR_ID(MFR), .DEV_ID(DEV), .SIG_ID(SIG), .TYPE_ID(TYP), .CAP_ID(CAP),
      .OP_SIG(OPS), .OP_PAIR(OPP), .OP_JEDEC(OPJ), .SIG_AS_PAIR(1'b0), .ADDR_BYTES(3)
   ) i_id_responder (
      .clk(clk), .rst_n(rst_n), .frm_active(frm_active), .wr_valid(wr_valid),
      .wr_byte(wr_byte), .rd_req(rd_req), .rd_valid(v0), .rd_byte(b0)
   );

   id_responder #(
      .MFR_ID(MFR), .DEV_ID(DEV), .SIG_ID(SIG), .TYPE_ID(TYP), .CAP_ID(CAP),
      .OP_SIG(OPS), .OP_PAIR(OPP), .OP_JEDEC(OPJ), .SIG_AS_PAIR(1'b1), .ADDR_BYTES(3)
   ) i_id_responder_alt (
      .clk(clk), .rst_n(rst_n), .frm_active(frm_active), .wr_valid(wr_valid),
      .wr_byte(wr_byte), .rd_req(rd_req), .rd_valid(v1), .rd_byte(b1)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // behavioural reference: answer to read i of the current frame
   function automatic logic [7:0] model(input bit alt, input int i);
      int n;
      int off;
      logic [7:0] op;
      bit pair;
      n = wq.size();
      if (n == 0) return 8'hFF;
      op = wq[0];
      if (op == OPJ) begin
         if (i == 0) return MFR;
         if (i == 1) return TYP;
         if (i == 2) return CAP;
         return 8'hFF;
      end
      pair = (op == OPP) || (op == OPS && alt);
      if (!pair && op != OPS) return 8'hFF;
      if (n < 4) return 8'hFF;
      if (!pair) return SIG;
      off = int'(wq[3]) + (n - 4) + i;
      return (off % 2 == 1) ? DEV : MFR;
   endfunction

   task automatic cyc(input bit act, input bit wv, input logic [7:0] wb,
                      input bit rr, input string tag);
      bit ev;
      logic [7:0] e0, e1;
      frm_active = act; wr_valid = wv; wr_byte = wb; rd_req = rr;
      ev = act && rr;
      e0 = 8'hFF; e1 = 8'hFF;
      if (ev) begin
         e0 = model(1'b0, rcount);
         e1 = model(1'b1, rcount);
      end
      if (!act) begin
         wq.delete(); rcount = 0; reading = 0;
      end else if (rr) begin
         rcount++; reading = 1;
      end else if (wv && !reading) begin
         wq.push_back(wb);
      end
      @(posedge clk);
      @(negedge clk);
      chk(v0 == ev, tag, "rd_valid basic", {7'b0, v0}, {7'b0, ev});
      chk(v1 == ev, tag, "rd_valid alt", {7'b0, v1}, {7'b0, ev});
      if (ev) begin
         chk(b0 == e0, tag, "rd_byte basic", b0, e0);
         chk(b1 == e1, tag, "rd_byte alt", b1, e1);
      end
   endtask

   task automatic frame(input int nrd, input string tag);
      foreach (stim[k]) cyc(1'b1, 1'b1, stim[k], 1'b0, tag);
      for (int r = 0; r < nrd; r++) cyc(1'b1, 1'b0, 8'h00, 1'b1, tag);
      cyc(1'b1, 1'b0, 8'h00, 1'b0, tag);
      cyc(1'b0, 1'b0, 8'h00, 1'b0, tag);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk(v0 == 1'b0 && v1 == 1'b0, "R11", "rd_valid in reset", {7'b0, v0 | v1}, 8'h00);
      chk(b0 == 8'hFF && b1 == 8'hFF, "R11", "rd_byte in reset", b0 & b1, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);
      chk(v0 == 1'b0 && b0 == 8'hFF, "R11", "after reset basic", b0, 8'hFF);
      chk(v1 == 1'b0 && b1 == 8'hFF, "R11", "after reset alt", b1, 8'hFF);

      // R6: JEDEC ID, tail of 0xFF, written bytes do not shift it
      stim = '{OPJ};                     frame(5, "R6");
      stim = '{OPJ, 8'h00, 8'h01};       frame(4, "R6");

      // R2: address LSB picks the starting byte, long alternation
      stim = '{OPP, 8'h00, 8'h00, 8'h00}; frame(4, "R2");
      stim = '{OPP, 8'h12, 8'h34, 8'h01}; frame(3, "R2");
      stim = '{OPP, 8'h00, 8'h00, 8'h02}; frame(40, "R2");

      // R3: surplus written bytes advance the offset
      stim = '{OPP, 8'h00, 8'h00, 8'h00, 8'h55};                 frame(3, "R3");
      stim = '{OPP, 8'h00, 8'h00, 8'h01, 8'h55, 8'hAA};          frame(3, "R3");
      stim = '{OPP, 8'h00, 8'h00, 8'h00, 8'h1, 8'h2, 8'h3, 8'h4, 8'h5, 8'h6, 8'h7};
      frame(4, "R3");

      // R1: short headers
      stim = '{OPP, 8'h00, 8'h00}; frame(3, "R1");
      stim = '{OPP};               frame(2, "R1");

      // R4 and R5: legacy signature in both variants
      stim = '{OPS, 8'h00, 8'h00, 8'h00}; frame(4, "R4");
      stim = '{OPS, 8'h00, 8'h00, 8'h01, 8'h77}; frame(3, "R5");
      stim = '{OPS, 8'h00};               frame(2, "R4");

      // R7: unknown opcode and empty frame
      stim = '{8'h03, 8'h00, 8'h00, 8'h00}; frame(2, "R7");
      stim = '{};                           frame(3, "R7");

      // R9: write after the first read, and write together with a read
      cyc(1'b1, 1'b1, OPP,   1'b0, "R9");
      cyc(1'b1, 1'b1, 8'h00, 1'b0, "R9");
      cyc(1'b1, 1'b1, 8'h00, 1'b0, "R9");
      cyc(1'b1, 1'b1, 8'h00, 1'b0, "R9");
      cyc(1'b1, 1'b0, 8'h00, 1'b1, "R9");
      cyc(1'b1, 1'b1, 8'h33, 1'b0, "R9");
      cyc(1'b1, 1'b1, 8'h44, 1'b1, "R9");
      cyc(1'b1, 1'b0, 8'h00, 1'b1, "R9");
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R9");
      cyc(1'b0, 1'b0, 8'h00, 1'b0, "R9");
      cyc(1'b1, 1'b1, OPS,   1'b0, "R9");
      cyc(1'b1, 1'b1, 8'h00, 1'b1, "R9");
      cyc(1'b1, 1'b0, 8'h00, 1'b1, "R9");
      cyc(1'b0, 1'b0, 8'h00, 1'b0, "R9");

      // R10: frame end clears state, R8: requests outside a frame
      cyc(1'b1, 1'b1, OPP,   1'b0, "R10");
      cyc(1'b1, 1'b1, 8'h00, 1'b0, "R10");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R8");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R8");
      stim = '{8'h00, 8'h01}; frame(2, "R10");
      stim = '{OPJ};          frame(2, "R10");
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R8");
      cyc(1'b1, 1'b0, 8'h00, 1'b1, "R8");
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R8");
      cyc(1'b0, 1'b0, 8'h00, 1'b0, "R8");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule